// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block forms the next control address for a microprogrammed control unit whose control store holds 128 words. The microinstruction sits outside the block. Each clock cycle the block receives four things from it and from the machine: the condition-select field, the branch-type field and the 7-bit jump address field of the current microinstruction; three status bits (indirect flag, accumulator sign and accumulator zero); and the 4-bit opcode of the machine instruction being executed.

A small input-logic stage does two jobs. It chooses one status test with the condition field. It then decodes the branch type and the test result into a two-bit select for a four-way address multiplexer, plus a load enable for the return register. The multiplexer picks one of four sources for the next address:

- the current address plus one, from a combinational adder;
- the jump address field;
- the saved return address;
- an address mapped from the opcode.

The chosen value is registered as the new control address on the rising clock edge. Opcode mapping gives every machine instruction a four-word routine in the lower half of the store. After reset the address points to the fetch routine at word 64.

Top module: `useq_next_addr`

## Requirements
- R1: While synchronous reset is high at a rising edge, `car` becomes 64 and `sbr` becomes 0.
- R2: The condition code selects the test: 00 is always true, 01 is `ind_bit`, 10 is `acc_sign`, 11 is `acc_zero`.
- R3: Branch code 00 (jump) with a true test loads `car` with `jump_addr`.
- R4: Branch codes 00 and 01 with a false test load `car` with `car`+1 modulo 128, so 127 wraps to 0.
- R5: Branch code 01 (call) with a true test loads `car` with `jump_addr` and loads `sbr` with the old `car`+1 modulo 128.
- R6: Branch code 10 (return) loads `car` from `sbr`, whatever the condition code, the status bits and the address field are.
- R7: Branch code 11 (map) loads `car` with bit 6 = 0, bits 5:2 = `opcode` and bits 1:0 = 0, whatever the condition code and the address field are.
- R8: `sbr` keeps its value on every cycle that is not a taken call, including a call whose test is false.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; both registers update on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cond_sel | input | 2 | Condition-select field of the microinstruction |
| br_type | input | 2 | Branch-type field of the microinstruction |
| jump_addr | input | 7 | Address field of the microinstruction |
| ind_bit | input | 1 | Indirect flag of the machine instruction |
| acc_sign | input | 1 | Accumulator sign status |
| acc_zero | input | 1 | Accumulator zero status |
| opcode | input | 4 | Opcode of the machine instruction |
| car | output | 7 | Control address register |
| sbr | output | 7 | Subroutine return address register |

## Verification
The bench uses the default parameters: a 7-bit address, a 4-bit opcode and a fetch start of 64. With a store this small, the wrap from 127 to 0 takes only a jump or two to reach. This holds both for a plain increment and for the return address saved by a call made at word 127. The bench also reaches both ends of the mapped range, opcode 0 mapping to address 0 and opcode 15 mapping to address 60. Every condition code is driven once with its status bit clear and once with it set. Return and map are driven with stray condition and address values, to show that those fields are ignored.

// File: rtl/useq_next_addr.sv
module useq_next_addr #(
  parameter int ADDR_W     = 7,
  parameter int OPC_W      = 4,
  parameter int FETCH_ADDR = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cond_sel,
  input  logic [1:0]        br_type,
  input  logic [ADDR_W-1:0] jump_addr,
  input  logic              ind_bit,
  input  logic              acc_sign,
  input  logic              acc_zero,
  input  logic [OPC_W-1:0]  opcode,
  output logic [ADDR_W-1:0] car,
  output logic [ADDR_W-1:0] sbr
);
  localparam int PAD_W = ADDR_W - OPC_W - 2;

  logic              test;
  logic [1:0]        sel;
  logic              sbr_load;
  logic [ADDR_W-1:0] car_inc;
  logic [ADDR_W-1:0] mapped;
  logic [ADDR_W-1:0] next_car;

  always_comb begin
    case (cond_sel)
      2'd0:    test = 1'b1;
      2'd1:    test = ind_bit;
      2'd2:    test = acc_sign;
      default: test = acc_zero;
    endcase
  end

  always_comb begin
    case (br_type)
      2'd0, 2'd1: sel = test ? 2'd1 : 2'd0;
      2'd2:       sel = 2'd2;
      default:    sel = 2'd3;
    endcase
  end

  assign sbr_load = (br_type == 2'd1) && test;
  assign car_inc  = car + ADDR_W'(1);
  assign mapped   = {{PAD_W{1'b0}}, opcode, 2'b00};

  always_comb begin
    case (sel)
      2'd0:    next_car = car_inc;
      2'd1:    next_car = jump_addr;
      2'd2:    next_car = sbr;
      default: next_car = mapped;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      car <= ADDR_W'(FETCH_ADDR);
      sbr <= '0;
    end else begin
      car <= next_car;
      if (sbr_load) sbr <= car_inc;
    end
  end
endmodule

// File: rtl/useq_next_addr_chk.sv
module useq_next_addr_chk #(
  parameter int ADDR_W     = 7,
  parameter int OPC_W      = 4,
  parameter int FETCH_ADDR = 64
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        cond_sel,
  input logic [1:0]        br_type,
  input logic [ADDR_W-1:0] jump_addr,
  input logic              ind_bit,
  input logic              acc_sign,
  input logic              acc_zero,
  input logic [OPC_W-1:0]  opcode,
  input logic [ADDR_W-1:0] car,
  input logic [ADDR_W-1:0] sbr
);
  logic cond_ok;
  assign cond_ok = (cond_sel == 2'd0) || (cond_sel == 2'd1 && ind_bit) ||
                   (cond_sel == 2'd2 && acc_sign) || (cond_sel == 2'd3 && acc_zero);

  // R1
  reset_fetch_chk: assert property (@(posedge clk)
    rst |=> (car == ADDR_W'(FETCH_ADDR) && sbr == '0));

  // R3
  jump_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (br_type == 2'd0 && cond_ok) |=> car == $past(jump_addr));

  // R4
  not_taken_inc_chk: assert property (@(posedge clk) disable iff (rst)
    (!br_type[1] && !cond_ok) |=> car == ADDR_W'($past(car) + 1'b1));

  // R5
  call_save_chk: assert property (@(posedge clk) disable iff (rst)
    (br_type == 2'd1 && cond_ok) |=> (sbr == ADDR_W'($past(car) + 1'b1) && car == $past(jump_addr)));

  // R6
  ret_restore_chk: assert property (@(posedge clk) disable iff (rst)
    (br_type == 2'd2) |=> car == $past(sbr));

  // R7
  map_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (br_type == 2'd3) |=> (car[1:0] == 2'b00 && car[ADDR_W-1] == 1'b0 && car[OPC_W+1:2] == $past(opcode)));

  // R8
  sbr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(br_type == 2'd1 && cond_ok) |=> $stable(sbr));
endmodule

bind useq_next_addr useq_next_addr_chk #(
  .ADDR_W(ADDR_W), .OPC_W(OPC_W), .FETCH_ADDR(FETCH_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .cond_sel(cond_sel), .br_type(br_type),
  .jump_addr(jump_addr), .ind_bit(ind_bit), .acc_sign(acc_sign),
  .acc_zero(acc_zero), .opcode(opcode), .car(car), .sbr(sbr)
);

// File: tb/tb_useq_next_addr.sv
module tb_useq_next_addr;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] cond_sel = '0;
  logic [1:0] br_type = '0;
  logic [6:0] jump_addr = '0;
  logic       ind_bit = 1'b0;
  logic       acc_sign = 1'b0;
  logic       acc_zero = 1'b0;
  logic [3:0] opcode = '0;
  logic [6:0] car;
  logic [6:0] sbr;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  useq_next_addr dut (
    .clk(clk), .rst(rst), .cond_sel(cond_sel), .br_type(br_type),
    .jump_addr(jump_addr), .ind_bit(ind_bit), .acc_sign(acc_sign),
    .acc_zero(acc_zero), .opcode(opcode), .car(car), .sbr(sbr)
  );

  // {br, cond, addr, ind, sign, zero, opcode, exp_car, exp_sbr}
  localparam int NV = 19;
  localparam logic [31:0] VEC [NV] = '{
    {2'd0, 2'd0, 7'd5,   1'b0, 1'b0, 1'b0, 4'd0,  7'd5,   7'd0},
    {2'd0, 2'd1, 7'd20,  1'b0, 1'b0, 1'b0, 4'd0,  7'd6,   7'd0},
    {2'd0, 2'd1, 7'd20,  1'b1, 1'b0, 1'b0, 4'd0,  7'd20,  7'd0},
    {2'd0, 2'd2, 7'd3,   1'b0, 1'b0, 1'b0, 4'd0,  7'd21,  7'd0},
    {2'd0, 2'd2, 7'd40,  1'b0, 1'b1, 1'b0, 4'd0,  7'd40,  7'd0},
    {2'd0, 2'd3, 7'd2,   1'b0, 1'b0, 1'b0, 4'd0,  7'd41,  7'd0},
    {2'd0, 2'd3, 7'd90,  1'b0, 1'b0, 1'b1, 4'd0,  7'd90,  7'd0},
    {2'd1, 2'd0, 7'd100, 1'b0, 1'b0, 1'b0, 4'd0,  7'd100, 7'd91},
    {2'd1, 2'd3, 7'd10,  1'b0, 1'b0, 1'b0, 4'd0,  7'd101, 7'd91},
    {2'd3, 2'd0, 7'd33,  1'b0, 1'b0, 1'b0, 4'd5,  7'd20,  7'd91},
    {2'd2, 2'd1, 7'd7,   1'b0, 1'b0, 1'b0, 4'd9,  7'd91,  7'd91},
    {2'd3, 2'd2, 7'd127, 1'b0, 1'b0, 1'b0, 4'd15, 7'd60,  7'd91},
    {2'd3, 2'd1, 7'd1,   1'b0, 1'b0, 1'b0, 4'd0,  7'd0,   7'd91},
    {2'd0, 2'd0, 7'd127, 1'b0, 1'b0, 1'b0, 4'd0,  7'd127, 7'd91},
    {2'd0, 2'd3, 7'd50,  1'b0, 1'b0, 1'b0, 4'd0,  7'd0,   7'd91},
    {2'd1, 2'd2, 7'd126, 1'b0, 1'b1, 1'b0, 4'd0,  7'd126, 7'd1},
    {2'd0, 2'd1, 7'd9,   1'b0, 1'b0, 1'b0, 4'd0,  7'd127, 7'd1},
    {2'd1, 2'd1, 7'd9,   1'b0, 1'b0, 1'b0, 4'd0,  7'd0,   7'd1},
    {2'd2, 2'd3, 7'd55,  1'b1, 1'b1, 1'b1, 4'd3,  7'd1,   7'd1}
  };

  task automatic check(input string req, input logic [6:0] exp_car, input logic [6:0] exp_sbr);
    checks++;
    if (car !== exp_car || sbr !== exp_sbr) begin
      errors++;
      $display("FAIL %s: car=%0d sbr=%0d, expected car=%0d sbr=%0d", req, car, sbr, exp_car, exp_sbr);
    end
  endtask

  task automatic step(input logic [1:0] b, input logic [1:0] c, input logic [6:0] a,
                      input logic i, input logic s, input logic z, input logic [3:0] o);
    br_type = b; cond_sel = c; jump_addr = a;
    ind_bit = i; acc_sign = s; acc_zero = z; opcode = o;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R1 reset", 7'd64, 7'd0);
    rst = 1'b0;
    for (int k = 0; k < NV; k++) begin
      logic [31:0] v;
      v = VEC[k];
      step(v[31:30], v[29:28], v[27:21], v[20], v[19], v[18], v[17:14]);
      case (v[31:30])
        2'd0:    check($sformatf("R2 R3 R4 vec %0d jump", k), v[13:7], v[6:0]);
        2'd1:    check($sformatf("R5 R8 R4 vec %0d call", k), v[13:7], v[6:0]);
        2'd2:    check($sformatf("R6 vec %0d return", k), v[13:7], v[6:0]);
        default: check($sformatf("R7 vec %0d map", k), v[13:7], v[6:0]);
      endcase
    end
    // R1: reset in mid-run returns to the fetch routine
    rst = 1'b1;
    step(2'd0, 2'd0, 7'd12, 1'b0, 1'b0, 1'b0, 4'd0);
    check("R1 mid-run reset", 7'd64, 7'd0);
    rst = 1'b0;
    // R5: call from word 127 saves a wrapped return address
    step(2'd1, 2'd0, 7'd50, 1'b0, 1'b0, 1'b0, 4'd0);
    check("R5 call from 64", 7'd50, 7'd65);
    step(2'd0, 2'd0, 7'd127, 1'b0, 1'b0, 1'b0, 4'd0);
    check("R3 jump to 127", 7'd127, 7'd65);
    step(2'd1, 2'd0, 7'd9, 1'b0, 1'b0, 1'b0, 4'd0);
    check("R5 call at 127 wraps saved address", 7'd9, 7'd0);
    step(2'd2, 2'd0, 7'd77, 1'b0, 1'b0, 1'b0, 4'd0);
    check("R6 return to wrapped address", 7'd0, 7'd0);
    // R7: map ignores status bits and address field
    step(2'd3, 2'd3, 7'd99, 1'b1, 1'b1, 1'b1, 4'd10);
    check("R7 map opcode 10", 7'd40, 7'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule